// File: doc/BRIEF.md
# Host-Read Status Freeze Synchronizer

This block keeps the eight status flags that a processor core exposes to an external host. The host reads them with no timing relationship to the processor clock. The core sets or clears any flag on any cycle. A host enable strobe, asynchronous to the core clock, is brought into the clock domain. While that strobe is active, the byte presented to the host is frozen, so a read never catches a flag halfway through a change. That matters most for the two host flags, which carry meaning only as an encoded pair.

Requests that arrive during a freeze are not dropped. They go into a live flag register. The host-facing shadow copy picks them up on the first clock edge after the synchronized enable falls. The enable passes through a rising-edge stage and then a falling-edge stage. This gives a 1.5-cycle path into the freeze gate, and a low phase of about 1.5 cycles is enough to let the shadow refresh even when the host polls without pause.

Top module: `hsf_status_freeze`

## Requirements
- R1: While `rst` is high at a rising edge, `status_out` becomes 8'h06 at that edge. The bits are: bit0 receive-full, bit1 transmit-empty, bit2 transmit-ready, bit3 host flag low, bit4 host flag high, bit5 DMA mode, bit6 host request, bit7 host command. Transmit-empty and transmit-ready reset to 1 and every other flag resets to 0.
- R2: A `set_req` bit sampled high at rising edge k makes that flag 1 in the live register at edge k. If no freeze is active, `status_out` shows it after edge k+1.
- R3: A `clr_req` bit sampled high at edge k, with the matching `set_req` bit low, makes that flag 0 in the same way.
- R4: When `set_req` and `clr_req` are both high for one flag at the same edge, the flag becomes 1.
- R5: A flag with neither request keeps its value.
- R6: When `host_en` is sampled high at edge k, `status_out` does not change at edge k+1 or at any later edge while `host_en` is still sampled high at the preceding edge.
- R7: Requests made while frozen are all kept. The first update after release shows every one of them.
- R8: When `host_en` is sampled low at edge m, `status_out` at edge m+1 takes the live value as it stood just before edge m+1.
- R9: When both host flags are set together, the host sees the pair go from 00 to 11 directly, never 01 or 10, with or without a freeze in between.
- R10: During continuous polling, a single low sample of `host_en` between high phases is enough to pass pending updates to `status_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 8 | Per-flag set requests from the core |
| clr_req | input | 8 | Per-flag clear requests from the core |
| host_en | input | 1 | Host enable strobe, asynchronous, active high |
| status_out | output | 8 | Frozen status byte driven to the host |

## Verification
The clocked checks sample `host_en` at rising edges. They assume that the strobe, like the core requests, changes away from both clock edges, so the synchronizer never resolves a metastable value. The stimulus changes every input three time units after a rising edge. That keeps it clear of the falling-edge stage as well. The host strobe is drawn as random high and low runs of one to six cycles, mixed with directed single-cycle gaps. This covers both the tight-polling case and long freezes.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  localparam int unsigned NFLAGS = 8;
  typedef logic [NFLAGS-1:0] flags_t;

  // bit positions of the status byte
  localparam int unsigned B_RXFULL  = 0;
  localparam int unsigned B_TXEMPTY = 1;
  localparam int unsigned B_TXRDY   = 2;
  localparam int unsigned B_HFLO    = 3;
  localparam int unsigned B_HFHI    = 4;
  localparam int unsigned B_DMA     = 5;
  localparam int unsigned B_HREQ    = 6;
  localparam int unsigned B_HCMD    = 7;

  localparam flags_t RST_VAL = flags_t'((1 << B_TXEMPTY) | (1 << B_TXRDY));
endpackage

// File: rtl/hsf_en_sync.sv
module hsf_en_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_en,
  output logic frz
);
  logic stage_a;
  logic stage_b;

  // first stage on the rising edge
  always_ff @(posedge clk) begin
    if (rst) stage_a <= 1'b0;
    else     stage_a <= async_en;
  end

  // second stage on the falling edge: 1.5 cycles total
  always_ff @(negedge clk) begin
    if (rst) stage_b <= 1'b0;
    else     stage_b <= stage_a;
  end

  assign frz = stage_b;
endmodule

// File: rtl/hsf_flag_bank.sv
module hsf_flag_bank
  import hsf_pkg::*;
#(
  parameter int unsigned WIDTH = NFLAGS,
  parameter logic [WIDTH-1:0] INIT = RST_VAL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] live_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)           bit_q <= INIT[g];
      else if (set_i[g]) bit_q <= 1'b1;   // set has priority
      else if (clr_i[g]) bit_q <= 1'b0;
    end
    assign live_o[g] = bit_q;
  end
endmodule

// File: rtl/hsf_shadow.sv
module hsf_shadow
  import hsf_pkg::*;
#(
  parameter int unsigned WIDTH = NFLAGS,
  parameter logic [WIDTH-1:0] INIT = RST_VAL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frz,
  input  logic [WIDTH-1:0] live_i,
  output logic [WIDTH-1:0] snap_o
);
  logic [WIDTH-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst)       snap_q <= INIT;
    else if (!frz) snap_q <= live_i;   // whole word copied at once
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/hsf_status_freeze.sv
module hsf_status_freeze
  import hsf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  set_req,
  input  logic [7:0]  clr_req,
  input  logic        host_en,
  output logic [7:0]  status_out
);
  logic   frz;
  flags_t live_q;

  hsf_en_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_en (host_en),
    .frz      (frz)
  );

  hsf_flag_bank #(.WIDTH(NFLAGS), .INIT(RST_VAL)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_req),
    .clr_i  (clr_req),
    .live_o (live_q)
  );

  hsf_shadow #(.WIDTH(NFLAGS), .INIT(RST_VAL)) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .frz    (frz),
    .live_i (live_q),
    .snap_o (status_out)
  );
endmodule

// File: rtl/hsf_status_freeze_chk.sv
module hsf_status_freeze_chk
  import hsf_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] set_req,
  input logic [7:0] clr_req,
  input logic       host_en,
  input logic [7:0] status_out,
  input logic [7:0] live_q
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_value_chk: assert property (@(posedge clk) rst |=> status_out == RST_VAL);

  for (genvar g = 0; g < NFLAGS; g++) begin : g_chk
    // R2
    set_takes_chk: assert property (@(posedge clk) disable iff (rst)
      set_req[g] |=> live_q[g]);
    // R3
    clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_req[g] && !set_req[g]) |=> !live_q[g]);
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_req[g] && set_req[g]) |=> live_q[g]);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_req[g] && !set_req[g]) |=> $stable(live_q[g]));
  end

  // R6
  frozen_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(host_en) && $past(host_en, 2)) |-> $stable(status_out));

  // R8
  release_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(host_en, 2)) |-> status_out == $past(live_q));
endmodule

bind hsf_status_freeze hsf_status_freeze_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .set_req    (set_req),
  .clr_req    (clr_req),
  .host_en    (host_en),
  .status_out (status_out),
  .live_q     (live_q)
);

// File: tb/hsf_status_freeze_bench.sv
module hsf_status_freeze_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RSTV = 8'h06;
  localparam logic [7:0] HF_PAIR = 8'h18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] set_req = '0;
  logic [7:0] clr_req = '0;
  logic       host_en = 1'b0;
  logic [7:0] status_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference state
  logic [7:0] m_live = RSTV;
  logic [7:0] m_shad = RSTV;
  logic       m_enq  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsf_status_freeze u_hsf_status_freeze (
    .clk(clk), .rst(rst), .set_req(set_req), .clr_req(clr_req),
    .host_en(host_en), .status_out(status_out)
  );

  function automatic logic [7:0] next_live(logic [7:0] cur, logic [7:0] s, logic [7:0] c);
    return (cur & ~c) | s;   // set dominates clear
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // drive inputs, cross one rising edge, update reference, compare
  task automatic cyc(logic [7:0] s, logic [7:0] c, logic en, string tag);
    logic frz_m;
    set_req = s; clr_req = c; host_en = en;
    @(posedge clk);
    frz_m = m_enq;
    if (!frz_m) m_shad = m_live;
    m_live = next_live(m_live, s, c);
    m_enq = en;
    #3;
    check(tag, status_out, m_shad);
    if (tag == "R9") begin
      n_chk++;
      if (status_out[4:3] == 2'b01 || status_out[4:3] == 2'b10) begin
        n_err++;
        $display("FAIL R9: pair got %b expected 00 or 11", status_out[4:3]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #3;
    check("R1", status_out, RSTV);
    rst = 1'b0;

    // R2: set host command
    cyc(8'h80, 8'h00, 1'b0, "R2");
    cyc(8'h00, 8'h00, 1'b0, "R2");
    check("R2", status_out, 8'h86);
    // R3: clear transmit-empty
    cyc(8'h00, 8'h02, 1'b0, "R3");
    cyc(8'h00, 8'h00, 1'b0, "R3");
    check("R3", status_out, 8'h84);
    // R4: set and clear together on receive-full
    cyc(8'h01, 8'h01, 1'b0, "R4");
    cyc(8'h00, 8'h00, 1'b0, "R4");
    check("R4", status_out, 8'h85);
    // R5: idle cycles hold
    cyc(8'h00, 8'h00, 1'b0, "R5");
    check("R5", status_out, 8'h85);

    // R6 / R7: freeze, accumulate, release
    cyc(8'h00, 8'h00, 1'b1, "R6");
    cyc(8'h20, 8'h00, 1'b1, "R6");
    cyc(8'h00, 8'h80, 1'b1, "R6");
    cyc(8'h40, 8'h00, 1'b1, "R6");
    check("R6", status_out, 8'h85);
    cyc(8'h00, 8'h00, 1'b0, "R8");
    cyc(8'h00, 8'h00, 1'b0, "R8");
    check("R7", status_out, 8'h65);

    // R9: pair 00 -> 11 inside a freeze, then release
    cyc(8'h00, 8'h00, 1'b1, "R9");
    cyc(HF_PAIR, 8'h00, 1'b1, "R9");
    cyc(8'h00, 8'h00, 1'b1, "R9");
    cyc(8'h00, 8'h00, 1'b0, "R9");
    cyc(8'h00, 8'h00, 1'b0, "R9");
    check("R9", status_out & HF_PAIR, HF_PAIR);
    // R9: pair back to 00 and up again without freeze
    cyc(8'h00, HF_PAIR, 1'b0, "R9");
    cyc(HF_PAIR, 8'h00, 1'b0, "R9");
    cyc(8'h00, 8'h00, 1'b0, "R9");

    // R10: tight polling with single-cycle gaps
    cyc(8'h00, 8'h00, 1'b1, "R10");
    cyc(8'h00, 8'h20, 1'b1, "R10");
    cyc(8'h00, 8'h00, 1'b0, "R10");
    cyc(8'h00, 8'h00, 1'b1, "R10");
    cyc(8'h00, 8'h00, 1'b1, "R10");
    check("R10", status_out[5], 1'b0);

    // random mix
    begin
      int run = 0;
      logic en = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        logic [7:0] s, c;
        if (run == 0) begin
          en = $urandom_range(1, 0) == 1;
          run = $urandom_range(6, 1);
        end
        run--;
        s = ($urandom_range(3, 0) == 0) ? 8'(1 << $urandom_range(7, 0)) : 8'h00;
        c = ($urandom_range(3, 0) == 0) ? 8'(1 << $urandom_range(7, 0)) : 8'h00;
        if ($urandom_range(15, 0) == 0) s = HF_PAIR;
        if ($urandom_range(15, 0) == 0) c = HF_PAIR;
        cyc(s, c, en, m_enq ? "R6" : "R2");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule